// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A small format register sets the frame layout: the number of data bits (5 to 8), whether a parity bit follows the data, how that bit is computed (odd, even, constant one or constant zero), and how long the stop period lasts. One bit of the same register forces the line low to signal a break. The top bit of the register is only stored and read back, and it has no effect on framing.

Bit timing comes from an external tick that pulses sixteen times per bit period. Each bit stays on the line for sixteen ticks, and the block only advances on ticks. A producer hands over one byte at a time with a valid/ready handshake. The frame format is captured at the moment a byte is accepted, so the format register can be rewritten freely while a frame is in flight. An empty flag tells the producer when the line has returned to idle.

Top module: `serial_framer_tx`

## Requirements
- R1: After reset the line is high, the empty flag and the ready flag are 1, and the format register reads 0x00. That value means 5 data bits, no parity, one stop bit and no break.
- R2: A frame starts with one low start bit, sends the data LSB first and returns the line to high. Every bit lasts exactly 16 ticks. The block changes nothing while the tick input is low.
- R3: Format bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Input bits above the word length are not sent.
- R4: Format bit 3 set to 1 adds one parity bit right after the data bits. Set to 0, no parity bit is sent.
- R5: When parity is on and bit 5 is 0, bit 4 = 0 makes the number of ones in data plus parity odd, and bit 4 = 1 makes it even.
- R6: When parity is on and bit 5 is 1, the parity bit is a constant: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R7: With format bit 2 at 0 the stop period is 16 ticks. With bit 2 at 1 it is 24 ticks for 5-bit words and 32 ticks for longer words.
- R8: While format bit 6 is 1 the line is held low, whether or not a frame is running. The frame keeps its timing underneath, and the line shows its normal value again once the bit is cleared.
- R9: A write to the format register can be read back on the next cycle. This includes bit 7, which has no effect on framing.
- R10: The frame format is captured when a byte is accepted. A register write made during a frame changes only later frames.
- R11: A byte is accepted on a clock edge where valid and ready are both high. Ready and empty are high only while no frame is running. Empty goes back high on the clock edge that ends the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Baud tick, 16 pulses per bit period |
| cfgWrEn | input | 1 | Format register write strobe |
| cfgWrData | input | 8 | Format register write value |
| cfgRdData | output | 8 | Format register contents |
| dataIn | input | 8 | Byte to transmit |
| dataValid | input | 1 | dataIn holds a byte to send |
| dataReady | output | 1 | Transmitter can accept a byte |
| txEmpty | output | 1 | No frame in progress |
| txOut | output | 1 | Serial output line |

## Verification
The hardest cases to reach from the ports are a format write that lands in the middle of a frame and a break that starts and ends inside a frame. In both, the format latched for the frame and the live register value differ, so the bench has to track both. The bench handles this with a frame-driving routine that can issue register writes at chosen cycle offsets after the handshake. That routine keeps a model of the register value in each cycle: expected line values come from the latched format, with a break mask taken from the live value. The same routine also runs a sweep over every format setting without the break bit. That sweep covers all word lengths, parity modes and stop lengths, and it checks the exact cycle on which empty returns.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [1:0] {
    OUT_MARK   = 2'd0,
    OUT_START  = 2'd1,
    OUT_DATA   = 2'd2,
    OUT_PARITY = 2'd3
  } outSel_e;

  typedef struct packed {
    logic    load;
    logic    shift;
    outSel_e sel;
  } txStrobe_t;
endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      dataValid,
  input  logic [1:0] cfgWordLen,
  input  logic      cfgParEn,
  input  logic      cfgStopLong,
  output logic      dataReady,
  output logic      txEmpty,
  output txStrobe_t strobe
);
  localparam int MIN_BITS   = MAX_BITS - 3;
  localparam int HALF_TICKS = TICKS_PER_BIT / 2;
  localparam int CNT_W      = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int IDX_W      = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP1_LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(TICKS_PER_BIT + HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] STOP2_LAST = CNT_W'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} state_e;

  state_e           state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] bitsLast;
  logic             parEnLatched;
  logic [CNT_W-1:0] stopLast;
  logic             bitEnd;
  logic             stopEnd;
  logic [CNT_W-1:0] stopLastNext;

  assign bitEnd  = tick16 && (tickCnt == BIT_LAST);
  assign stopEnd = tick16 && (tickCnt == stopLast);

  always_comb begin
    if (!cfgStopLong)           stopLastNext = STOP1_LAST;
    else if (cfgWordLen == 2'd0) stopLastNext = STOP15_LAST;
    else                        stopLastNext = STOP2_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      tickCnt      <= '0;
      bitIdx       <= '0;
      bitsLast     <= '0;
      parEnLatched <= 1'b0;
      stopLast     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (dataValid) begin
            state        <= ST_START;
            tickCnt      <= '0;
            bitIdx       <= '0;
            bitsLast     <= IDX_W'(MIN_BITS - 1) + IDX_W'(cfgWordLen);
            parEnLatched <= cfgParEn;
            stopLast     <= stopLastNext;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            state   <= ST_DATA;
            tickCnt <= '0;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (bitIdx == bitsLast) state <= parEnLatched ? ST_PAR : ST_STOP;
            else                    bitIdx <= bitIdx + 1'b1;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bitEnd) begin
            state   <= ST_STOP;
            tickCnt <= '0;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (stopEnd) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dataReady = (state == ST_IDLE);
  assign txEmpty   = (state == ST_IDLE);

  always_comb begin
    strobe.load  = (state == ST_IDLE) && dataValid;
    strobe.shift = (state == ST_DATA) && bitEnd;
    unique case (state)
      ST_START: strobe.sel = OUT_START;
      ST_DATA:  strobe.sel = OUT_DATA;
      ST_PAR:   strobe.sel = OUT_PARITY;
      default:  strobe.sel = OUT_MARK;
    endcase
  end
endmodule

// File: rtl/sftx_dpath.sv
module sftx_dpath
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic [DATA_W-1:0] dataIn,
  input  txStrobe_t         strobe,
  output logic [7:0]        cfgReg,
  output logic              txOut
);
  localparam int LEN_SPAN = 3;

  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [DATA_W-1:0] wordMask;
  logic [DATA_W-1:0] maskedData;
  logic              onesOdd;
  logic              parNext;
  logic              lineBit;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= 8'h00;
    else if (cfgWrEn) cfgReg <= cfgWrData;
  end

  assign wordMask   = {DATA_W{1'b1}} >> (2'(LEN_SPAN) - cfgReg[1:0]);
  assign maskedData = dataIn & wordMask;
  assign onesOdd    = ^maskedData;

  always_comb begin
    if (cfgReg[5])      parNext = ~cfgReg[4];
    else if (cfgReg[4]) parNext = onesOdd;
    else                parNext = ~onesOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= dataIn;
      parBit   <= parNext;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    unique case (strobe.sel)
      OUT_START:  lineBit = 1'b0;
      OUT_DATA:   lineBit = shiftReg[0];
      OUT_PARITY: lineBit = parBit;
      default:    lineBit = 1'b1;
    endcase
  end

  assign txOut = cfgReg[6] ? 1'b0 : lineBit;
endmodule

// File: rtl/serial_framer_tx.sv
module serial_framer_tx
  import sftx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  output logic              dataReady,
  output logic              txEmpty,
  output logic              txOut
);
  txStrobe_t  strobe;
  logic [7:0] cfgReg;

  sftx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .MAX_BITS(DATA_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick16      (tick16),
    .dataValid   (dataValid),
    .cfgWordLen  (cfgReg[1:0]),
    .cfgParEn    (cfgReg[3]),
    .cfgStopLong (cfgReg[2]),
    .dataReady   (dataReady),
    .txEmpty     (txEmpty),
    .strobe      (strobe)
  );

  sftx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .cfgReg    (cfgReg),
    .txOut     (txOut)
  );

  assign cfgRdData = cfgReg;
endmodule

// File: rtl/serial_framer_tx_chk.sv
module serial_framer_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick16,
  input logic       cfgWrEn,
  input logic [7:0] cfgWrData,
  input logic [7:0] cfgRdData,
  input logic       dataValid,
  input logic       dataReady,
  input logic       txEmpty,
  input logic       txOut
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[6] |-> !txOut); // R8

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !cfgRdData[6]) |-> txOut); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady && !cfgRdData[6] && !cfgWrEn) |=> !txOut); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick16 && !txEmpty && !cfgWrEn) |=> $stable(txOut)); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> !txEmpty); // R11

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !dataValid) |=> txEmpty); // R11

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData == $past(cfgWrData))); // R9
endmodule

bind serial_framer_tx serial_framer_tx_chk uChk (.*);

// File: tb/tb_serial_framer_tx.sv
`timescale 1ns/1ps
module tb_serial_framer_tx;
  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16;
  logic       cfgWrEn;
  logic [7:0] cfgWrData;
  logic [7:0] cfgRdData;
  logic [7:0] dataIn;
  logic       dataValid;
  logic       dataReady;
  logic       txEmpty;
  logic       txOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] regNow;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_framer_tx dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .dataIn(dataIn),
    .dataValid(dataValid), .dataReady(dataReady), .txEmpty(txEmpty),
    .txOut(txOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeCfg(input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
    regNow = val;
    check(cfgRdData == val, "R9 readback", cfgRdData, val);
  endtask

  // Sends one byte; optional register writes at cycle offsets wr1/wr2 after acceptance.
  task automatic runFrame(input logic [7:0] d, input int wr1, input logic [7:0] v1,
                          input int wr2, input logic [7:0] v2, input string extra);
    logic [7:0] fcfg;
    int n, p, stopT, body, frameLen, idx, expBit, ones;
    logic parExp;
    bit pend;
    logic [7:0] pendVal;
    string req;
    fcfg = regNow;
    n = 5 + int'(fcfg[1:0]);
    p = int'(fcfg[3]);
    stopT = fcfg[2] ? ((fcfg[1:0] == 2'd0) ? 24 : 32) : 16;
    body = 1 + n + p;
    frameLen = 16 * body + stopT;
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    if (fcfg[5]) parExp = ~fcfg[4];
    else if (fcfg[4]) parExp = (ones % 2 == 1);
    else parExp = (ones % 2 == 0);
    pend = 0;
    pendVal = 8'h00;

    @(negedge clk);
    check(dataReady && txEmpty, {"R11 ready before send ", extra}, {dataReady, txEmpty}, 3);
    dataValid = 1'b1;
    dataIn = d;
    @(negedge clk);
    dataValid = 1'b0;
    dataIn = ~d;
    check(!dataReady && !txEmpty, {"R11 busy after accept ", extra}, {dataReady, txEmpty}, 0);
    for (int c = 1; c <= frameLen; c++) begin
      @(negedge clk);
      if (pend) begin
        pend = 0;
        cfgWrEn = 1'b0;
        regNow = pendVal;
      end
      if (c % 16 == 8 && c < frameLen) begin
        idx = c / 16;
        if (idx == 0) begin expBit = 0; req = "R2 start"; end
        else if (idx <= n) begin expBit = int'(d[idx-1]); req = "R3 data"; end
        else if (p == 1 && idx == n + 1) begin
          expBit = int'(parExp); req = fcfg[5] ? "R6 stick parity" : "R5 parity";
        end
        else begin expBit = 1; req = (p == 0) ? "R4 no parity/stop" : "R7 stop"; end
        if (regNow[6]) begin expBit = 0; req = "R8 break"; end
        check(int'(txOut) == expBit, {req, " ", extra}, txOut, expBit);
      end
      if (c == frameLen - 1) begin
        check(!txEmpty, {"R7 stop length ", extra}, txEmpty, 0);
        check(int'(txOut) == (regNow[6] ? 0 : 1), {"R7 last stop tick ", extra}, txOut, !regNow[6]);
      end
      if (c == frameLen)
        check(txEmpty && dataReady, {"R11 empty at stop end ", extra}, txEmpty, 1);
      if (c == wr1 || c == wr2) begin
        pend = 1;
        pendVal = (c == wr1) ? v1 : v2;
        cfgWrEn = 1'b1;
        cfgWrData = pendVal;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    rstN = 1'b0;
    tick16 = 1'b1;
    cfgWrEn = 1'b0;
    cfgWrData = 8'h00;
    dataIn = 8'h00;
    dataValid = 1'b0;
    regNow = 8'h00;
    repeat (4) @(negedge clk);
    check(txOut == 1'b1, "R1 line idle high", txOut, 1);
    check(txEmpty && dataReady, "R1 empty and ready", {txEmpty, dataReady}, 3);
    check(cfgRdData == 8'h00, "R1 register reset", cfgRdData, 0);
    rstN = 1'b1;

    // R1: default framing is 5 bits, no parity, one stop bit
    runFrame(8'hE6, -1, 8'h00, -1, 8'h00, "R1 default");

    // Sweep of every format value without break: R3 R4 R5 R6 R7 R9
    for (int f = 0; f < 256; f++) begin
      if (f[6]) continue;
      writeCfg(8'(f));
      runFrame(8'(f * 37 + 13), -1, 8'h00, -1, 8'h00, "sweep");
      runFrame(~8'(f * 37 + 13), -1, 8'h00, -1, 8'h00, "sweep");
    end

    // R10: a write during a frame does not alter that frame
    writeCfg(8'h1F);
    runFrame(8'hC3, 20, 8'h00, -1, 8'h00, "R10 mid-frame write");
    check(cfgRdData == 8'h00, "R10 new value stored", cfgRdData, 0);
    runFrame(8'h5A, -1, 8'h00, -1, 8'h00, "R10 next frame uses new format");

    // R8: break set and cleared inside a frame; timing unchanged
    writeCfg(8'h0B);
    runFrame(8'h96, 30, 8'h4B, 70, 8'h0B, "R8 break in frame");
    writeCfg(8'h40);
    check(txOut == 1'b0, "R8 break while idle", txOut, 0);
    writeCfg(8'h00);
    check(txOut == 1'b1, "R8 break released", txOut, 1);

    // R2: no progress without ticks; 5-bit frame needs 112 ticks total
    @(negedge clk);
    dataValid = 1'b1;
    dataIn = 8'h1F;
    @(negedge clk);
    dataValid = 1'b0;
    tick16 = 1'b0;
    repeat (40) @(negedge clk);
    check(txOut == 1'b0 && !txEmpty, "R2 frozen without tick", {txOut, txEmpty}, 0);
    tick16 = 1'b1;
    cnt = 0;
    while (!txEmpty && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 112, "R2 tick count per frame", cnt, 112);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule